// File: doc/BRIEF.md
# Pairwise Dependence Window Checker

The block decides whether instructions may execute side by side. Each instruction is described by two bitmasks over a fixed set of variables: the variables it reads and the variables it writes. A direct pair path takes an earlier and a later instruction and reports, one cycle later, three separate dependence flags and a parallel flag. The three flags are flow (read after write), anti (write after read) and output (write after write). The parallel flag is set only when all three mask intersections are empty.

A second path collects a window of up to eight instructions, one per `in_valid` strobe, in program order. The first instruction entered is index 0. It then scans the window and fills a symmetric parallelism matrix. When the scan ends, `win_done` pulses and software-free logic downstream reads the matrix one row per cycle through `row_idx`/`row_out`.

The window controller has four states:
- `ST_FILL` collects entries.
- `ST_SCAN` compares one column per cycle against all earlier entries.
- `ST_DONE` is the one-cycle done state.
- `ST_HOLD` keeps the matrix for reading.

Transitions:
- FILL→SCAN on an accepted entry that carries `in_last` or that is the eighth.
- SCAN→SCAN while columns remain.
- SCAN→DONE after the last column.
- DONE→HOLD unconditionally.
- HOLD→FILL on a new entry without `in_last`.
- HOLD→SCAN on a new entry with `in_last`.
- FILL→FILL and HOLD→HOLD while no entry arrives.

Top module: `dep_window_checker`

## Requirements
- R1: `pair_flow` is 1 one cycle after inputs where `pb_rd & pa_wr` is non-zero (later reads what earlier writes), else 0.
- R2: `pair_anti` is 1 one cycle after inputs where `pb_wr & pa_rd` is non-zero (later writes what earlier reads), else 0.
- R3: `pair_out` is 1 one cycle after inputs where `pa_wr & pb_wr` is non-zero, else 0.
- R4: `pair_par` is 1 one cycle after inputs exactly when all three intersections of R1–R3 are empty.
- R5: Entries are accepted on `in_valid` in `ST_FILL` or `ST_HOLD` and are numbered from 0 in arrival order. The window closes after the entry carrying `in_last`, or after the eighth entry even without `in_last`.
- R6: After a window of N entries, matrix bit (r,c) for r≠c and both below N is 1 exactly when entries min(r,c) (earlier) and max(r,c) (later) have no flow, anti or output dependence. The matrix is symmetric.
- R7: Diagonal bits are 0, and every bit whose row or column is N or above is 0.
- R8: `win_done` is high for exactly one cycle. Its first high cycle follows the N-th rising edge after the edge that accepted the closing entry.
- R9: `in_valid` in `ST_SCAN` or `ST_DONE` is ignored; it neither adds an entry nor changes the matrix.
- R10: An entry accepted in `ST_HOLD` starts a new window as index 0 and clears the whole previous matrix.
- R11: While reset is held and right after it, all pair outputs, `win_done` and `row_out` are 0.
- R12: `row_out` bit c equals matrix bit (`row_idx`, c), where `row_idx` is the value sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_rd | input | 16 | Read mask of the earlier instruction of the direct pair |
| pa_wr | input | 16 | Write mask of the earlier instruction of the direct pair |
| pb_rd | input | 16 | Read mask of the later instruction of the direct pair |
| pb_wr | input | 16 | Write mask of the later instruction of the direct pair |
| pair_flow | output | 1 | Registered flow dependence flag |
| pair_anti | output | 1 | Registered anti dependence flag |
| pair_out | output | 1 | Registered output dependence flag |
| pair_par | output | 1 | Registered may-run-in-parallel flag |
| in_valid | input | 1 | Window entry strobe |
| in_last | input | 1 | Marks the entry as the last of the window |
| in_rd | input | 16 | Read mask of the window entry |
| in_wr | input | 16 | Write mask of the window entry |
| win_done | output | 1 | One-cycle pulse when the matrix is complete |
| row_idx | input | 3 | Matrix row to read |
| row_out | output | 8 | Registered matrix row, bit c is column c |

## Verification
Two things can land in one cycle: a fresh `in_valid` strobe and the window controller being busy scanning or signalling done. The bench forces this by holding `in_valid` high with unrelated masks for every scan cycle and the done cycle of a window. It then reads all eight rows and requires them to match the model of the entries actually accepted, and requires the done pulse to land at the predicted edge. The direct pair path runs in parallel with window traffic on every cycle, and a per-clock behavioural model judges all four pair flags each cycle.

// File: rtl/depchk_pkg.sv
package depchk_pkg;
    localparam int DEF_NVAR = 16;
    localparam int DEF_NWIN = 8;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_SCAN,
        ST_DONE,
        ST_HOLD
    } win_state_e;

    typedef struct packed {
        logic flow;
        logic anti;
        logic outd;
    } dep_kind_t;
endpackage

// File: rtl/dep_pair_classify.sv
module dep_pair_classify
    import depchk_pkg::*;
#(
    parameter int NVAR = DEF_NVAR
) (
    input  logic [NVAR-1:0] early_rd,
    input  logic [NVAR-1:0] early_wr,
    input  logic [NVAR-1:0] late_rd,
    input  logic [NVAR-1:0] late_wr,
    output dep_kind_t       kind
);
    always_comb begin
        kind.flow = |(late_rd & early_wr);
        kind.anti = |(late_wr & early_rd);
        kind.outd = |(late_wr & early_wr);
    end
endmodule

// File: rtl/dep_window_store.sv
module dep_window_store #(
    parameter int NVAR = 16,
    parameter int NWIN = 8,
    localparam int IDXW = $clog2(NWIN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDXW-1:0]            widx,
    input  logic [NVAR-1:0]            wrd,
    input  logic [NVAR-1:0]            wwr,
    output logic [NWIN-1:0][NVAR-1:0]  rd_all,
    output logic [NWIN-1:0][NVAR-1:0]  wr_all
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_all <= '0;
            wr_all <= '0;
        end else if (we) begin
            rd_all[widx] <= wrd;
            wr_all[widx] <= wwr;
        end
    end
endmodule

// File: rtl/dep_par_matrix.sv
module dep_par_matrix #(
    parameter int NWIN = 8,
    localparam int IDXW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            upd,
    input  logic [IDXW-1:0] upd_col,
    input  logic [NWIN-1:0] col_par,
    input  logic [IDXW-1:0] row_sel,
    output logic [NWIN-1:0] row_q
);
    logic [NWIN-1:0][NWIN-1:0] mat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mat <= '0;
        end else if (clr) begin
            mat <= '0;
        end else if (upd) begin
            for (int r = 0; r < NWIN; r++) begin
                for (int c = 0; c < NWIN; c++) begin
                    if (upd_col == IDXW'(c))
                        mat[r][c] <= col_par[r];
                    else if (upd_col == IDXW'(r))
                        mat[r][c] <= col_par[c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= mat[row_sel];
    end

    function automatic logic sym_ok(input logic [NWIN-1:0][NWIN-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int r = 0; r < NWIN; r++)
            for (int c = 0; c < NWIN; c++)
                if (m[r][c] != m[c][r]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic diag_ok(input logic [NWIN-1:0][NWIN-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int r = 0; r < NWIN; r++)
            if (m[r][r]) ok = 1'b0;
        return ok;
    endfunction

    assert_symmetric_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ok(mat));

    assert_diag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        diag_ok(mat));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mat == '0));
endmodule

// File: rtl/dep_window_checker.sv
module dep_window_checker
    import depchk_pkg::*;
#(
    parameter int NVAR = DEF_NVAR,
    parameter int NWIN = DEF_NWIN,
    localparam int IDXW = $clog2(NWIN),
    localparam int CNTW = $clog2(NWIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVAR-1:0] pa_rd,
    input  logic [NVAR-1:0] pa_wr,
    input  logic [NVAR-1:0] pb_rd,
    input  logic [NVAR-1:0] pb_wr,
    output logic            pair_flow,
    output logic            pair_anti,
    output logic            pair_out,
    output logic            pair_par,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic [NVAR-1:0] in_rd,
    input  logic [NVAR-1:0] in_wr,
    output logic            win_done,
    input  logic [IDXW-1:0] row_idx,
    output logic [NWIN-1:0] row_out
);
    win_state_e state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [IDXW-1:0] scan_q;
    logic            accept, in_hold, scan_last, fill_full, upd, clr;
    logic [IDXW-1:0] wr_idx;
    logic [NWIN-1:0][NVAR-1:0] rd_all, wr_all;
    logic [NWIN-1:0] col_par;
    dep_kind_t       pk;
    logic            pair_ok_q;

    // ---------------- direct pair path ----------------
    dep_pair_classify #(.NVAR(NVAR)) u_pair (
        .early_rd(pa_rd), .early_wr(pa_wr),
        .late_rd (pb_rd), .late_wr (pb_wr),
        .kind    (pk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_flow <= 1'b0;
            pair_anti <= 1'b0;
            pair_out  <= 1'b0;
            pair_par  <= 1'b0;
            pair_ok_q <= 1'b0;
        end else begin
            pair_flow <= pk.flow;
            pair_anti <= pk.anti;
            pair_out  <= pk.outd;
            pair_par  <= (pk == '0);
            pair_ok_q <= 1'b1;
        end
    end

    // ---------------- window controller ----------------
    always_comb begin
        in_hold   = (state_q == ST_HOLD);
        accept    = in_valid && ((state_q == ST_FILL) || in_hold);
        wr_idx    = in_hold ? '0 : cnt_q[IDXW-1:0];
        fill_full = (cnt_q == CNTW'(NWIN - 1));
        scan_last = (CNTW'(scan_q) == (cnt_q - CNTW'(1)));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (in_valid && (in_last || fill_full)) state_d = ST_SCAN;
            ST_SCAN: if (scan_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_HOLD;
            ST_HOLD: if (in_valid) state_d = in_last ? ST_SCAN : ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            scan_q <= '0;
        end else begin
            if (accept) cnt_q <= in_hold ? CNTW'(1) : cnt_q + CNTW'(1);
            if (state_q == ST_SCAN) scan_q <= scan_q + IDXW'(1);
            else                    scan_q <= '0;
        end
    end

    always_comb begin
        win_done = (state_q == ST_DONE);
        upd      = (state_q == ST_SCAN);
        clr      = accept && in_hold;
    end

    // ---------------- window storage and comparators ----------------
    dep_window_store #(.NVAR(NVAR), .NWIN(NWIN)) u_store (
        .clk(clk), .rst_n(rst_n), .we(accept), .widx(wr_idx),
        .wrd(in_rd), .wwr(in_wr), .rd_all(rd_all), .wr_all(wr_all)
    );

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_cmp
        dep_kind_t k;
        dep_pair_classify #(.NVAR(NVAR)) u_cls (
            .early_rd(rd_all[gi]),     .early_wr(wr_all[gi]),
            .late_rd (rd_all[scan_q]), .late_wr (wr_all[scan_q]),
            .kind    (k)
        );
        assign col_par[gi] = (k == '0) && (IDXW'(gi) < scan_q);
    end

    dep_par_matrix #(.NWIN(NWIN)) u_mat (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .upd_col(scan_q),
        .col_par(col_par), .row_sel(row_idx), .row_q(row_out)
    );

    // ---------------- assertions ----------------
    assert_pair_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok_q |-> (pair_flow == |($past(pb_rd) & $past(pa_wr))));

    assert_pair_anti_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok_q |-> (pair_anti == |($past(pb_wr) & $past(pa_rd))));

    assert_pair_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok_q |-> (pair_out == |($past(pb_wr) & $past(pa_wr))));

    assert_pair_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_par |-> !(pair_flow || pair_anti || pair_out));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(NWIN));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    assert_scan_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> $stable(cnt_q));
endmodule

// File: tb/sim_dep_window_checker.sv
module sim_dep_window_checker;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [15:0] pa_rd, pa_wr, pb_rd, pb_wr, in_rd, in_wr;
    logic        pair_flow, pair_anti, pair_out, pair_par;
    logic        in_valid, in_last, win_done;
    logic [2:0]  row_idx;
    logic [7:0]  row_out;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    dep_window_checker u0 (
        .clk(clk), .rst_n(rst_n),
        .pa_rd(pa_rd), .pa_wr(pa_wr), .pb_rd(pb_rd), .pb_wr(pb_wr),
        .pair_flow(pair_flow), .pair_anti(pair_anti), .pair_out(pair_out), .pair_par(pair_par),
        .in_valid(in_valid), .in_last(in_last), .in_rd(in_rd), .in_wr(in_wr),
        .win_done(win_done), .row_idx(row_idx), .row_out(row_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock behavioural model of the pair path
    logic e_flow, e_anti, e_out, e_par;
    bit   e_ok;
    always @(posedge clk) begin
        if (!rst_n) begin
            e_ok <= 0; e_flow <= 0; e_anti <= 0; e_out <= 0; e_par <= 0;
        end else begin
            e_ok   <= 1;
            e_flow <= (pb_rd & pa_wr) != 0;
            e_anti <= (pb_wr & pa_rd) != 0;
            e_out  <= (pb_wr & pa_wr) != 0;
            e_par  <= ((pb_rd & pa_wr) == 0) && ((pb_wr & pa_rd) == 0) && ((pb_wr & pa_wr) == 0);
        end
    end
    always @(negedge clk) begin
        if (rst_n && e_ok && !finished) begin
            chk("R1 cycle flow", pair_flow, e_flow);
            chk("R2 cycle anti", pair_anti, e_anti);
            chk("R3 cycle out",  pair_out,  e_out);
            chk("R4 cycle par",  pair_par,  e_par);
        end
    end

    // window model
    logic [15:0] m_rd[8], m_wr[8];
    int m_cnt;

    function automatic logic [7:0] exp_row(input int r);
        logic [7:0] v;
        v = '0;
        for (int c = 0; c < 8; c++) begin
            if (r < m_cnt && c < m_cnt && r != c) begin
                int e, l;
                e = (r < c) ? r : c;
                l = (r < c) ? c : r;
                v[c] = ((m_rd[l] & m_wr[e]) == 0) && ((m_wr[l] & m_rd[e]) == 0) &&
                       ((m_wr[l] & m_wr[e]) == 0);
            end
        end
        return v;
    endfunction

    task automatic send(input logic [15:0] rd, input logic [15:0] wr, input logic last);
        @(negedge clk);
        in_valid = 1; in_rd = rd; in_wr = wr; in_last = last;
        m_rd[m_cnt] = rd; m_wr[m_cnt] = wr; m_cnt++;
    endtask

    task automatic wait_done(input bit junk);
        for (int n = 0; n <= m_cnt + 1; n++) begin
            @(negedge clk);
            chk("R8 done timing", win_done, (n == m_cnt));
            if (junk && n <= m_cnt) begin
                in_valid = 1; in_last = n[0];
                in_rd = 16'hFFFF ^ 16'(n); in_wr = 16'hFFFF;
            end else begin
                in_valid = 0; in_last = 0;
            end
        end
    endtask

    task automatic read_rows(input string tag);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk); row_idx = 3'(r);
            @(negedge clk); chk(tag, row_out, exp_row(r));
        end
    endtask

    task automatic pair(input logic [15:0] er, ew, lr, lw, input logic ef, ea, eo, ep);
        @(negedge clk);
        pa_rd = er; pa_wr = ew; pb_rd = lr; pb_wr = lw;
        @(negedge clk);
        chk("R1 pair flow", pair_flow, ef);
        chk("R2 pair anti", pair_anti, ea);
        chk("R3 pair out",  pair_out,  eo);
        chk("R4 pair par",  pair_par,  ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pa_rd = 0; pa_wr = 0; pb_rd = 0; pb_wr = 0;
        in_valid = 0; in_last = 0; in_rd = 0; in_wr = 0; row_idx = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        chk("R11 reset done", win_done, 0);
        chk("R11 reset par",  pair_par, 0);
        chk("R11 reset flow", pair_flow, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R11 after reset row", row_out, 0);
        chk("R11 after reset done", win_done, 0);

        // direct pair path; vars a0 b1 c2 d3 e4 x5 y6 z7
        pair(16'h0003, 16'h0020, 16'h000E, 16'h0040, 0, 0, 0, 1); // I1 vs I2 parallel
        pair(16'h0003, 16'h0020, 16'h0031, 16'h0080, 1, 0, 0, 0); // I1 vs I3 flow
        pair(16'h000E, 16'h0040, 16'h0031, 16'h0080, 0, 0, 0, 1); // I2 vs I3 parallel
        pair(16'h0001, 16'h0000, 16'h0000, 16'h0001, 0, 1, 0, 0); // anti only
        pair(16'h0000, 16'h8000, 16'h0000, 16'h8000, 0, 0, 1, 0); // output only
        pair(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0); // all three

        // window of five: C0 D1 E2 M3 G4 A5 B6 L7 F8 (R5, R6)
        send(16'h0006, 16'h0001, 0);
        send(16'h0011, 16'h0008, 0);
        send(16'h0041, 16'h0020, 0);
        send(16'h0088, 16'h0001, 0);
        send(16'h0014, 16'h0100, 1);
        wait_done(0);
        read_rows("R6 R7 R12 five-window row");
        @(negedge clk); row_idx = 3'd4;
        @(negedge clk); chk("R6 five-window row4", row_out, 8'h0F);

        // smaller window from hold must clear old matrix (R10)
        m_cnt = 0;
        send(16'h0003, 16'h0020, 0);
        send(16'h000E, 16'h0040, 0);
        send(16'h0031, 16'h0080, 1);
        wait_done(0);
        read_rows("R10 R7 three-window row");
        @(negedge clk); row_idx = 3'd1;
        @(negedge clk); chk("R6 three-window row1", row_out, 8'h05);

        // full window of eight closes without last; junk during scan ignored (R5, R9)
        m_cnt = 0;
        for (int k = 0; k < 8; k++)
            send((16'h1 << ((k * 3) % 16)) | (16'h1 << ((k + 5) % 16)),
                 16'h1 << ((k * 7 + 2) % 16), 0);
        wait_done(1);
        read_rows("R5 R9 eight-window row");

        // single-entry window: done after one cycle, all rows zero (R7, R8)
        m_cnt = 0;
        send(16'h00FF, 16'h00FF, 1);
        wait_done(0);
        read_rows("R7 R8 one-window row");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule